// File: doc/BRIEF.md
# Adaptive Complex Chip Estimator

This block estimates transmitted chips in a spread-spectrum downlink receiver. A complex adaptive FIR filter runs over a centred window of 2F+1 chip-matched-filter samples. Each accepted sample produces one chip estimate: the inner product of the conjugated weight vector with the window. The weights then adapt by a channel-aided gradient rule. That rule needs a per-tap channel response vector and a signal-power constant, but no training sequence and no desired-response error.

All arithmetic is fixed point:

| Quantity | Width (bits) | Scale |
|---|---|---|
| Samples | 16 | 2^8 |
| Channel taps | 9 | 2^8 |
| Signal power | 9 | 2^8 |
| Weights | 9 | 2^14 |
| Step size | 8 | 2^18 |
| Estimates | 16 | 2^16 |

Right shifts are arithmetic and truncate. Every narrowing step saturates. The channel vector is written one tap at a time through a load port. Step size and signal power are static inputs held by the surrounding logic.

Top module: `gce_chip_est`

## Requirements
- R1: While rst_ni is low, est_valid_o is 0 and est_re_o/est_im_o are 0.
- R2: A sample presented with in_valid_i high in cycle t gives est_valid_o high in cycle t+2 only. est_valid_o is never high otherwise.
- R3: Accepted samples shift into a window that starts all zero. Tap k weights the sample accepted k samples before the newest. The centre tap F therefore weights the chip whose estimate appears once F later samples have been accepted.
- R4: est_re = sat16((Σ wr·xr + wi·xi) >>> 6) and est_im = sat16((Σ wr·xi − wi·xr) >>> 6). The sums are 32-bit and the shift floors, so for example −3984.375 gives −3985.
- R5: After each estimate, and before the next one is computed, every tap k updates:
  - e_re = sat32(((σ·hr_k) <<< 8) − (xr_k·û_re + xi_k·û_im))
  - e_im = sat32(((σ·hi_k) <<< 8) − (xi_k·û_re − xr_k·û_im))
  - w += (e·μ) >>> 28, where μ is unsigned and û is the saturated estimate.
- R6: Updated weight components saturate to [−256, 255].
- R7: Estimate components saturate to [−32768, 32767].
- R8: A cycle with h_we_i high and h_idx_i below 2F+1 writes that channel tap, effective for updates on later edges. Indices of 2F+1 and above write nothing. Channel taps reset to 0.
- R9: With mu_i = 0 the weights do not change.
- R10: Cycles with in_valid_i low change neither the window nor the weights.
- R11: After reset the centre weight is 255 + j0 and all other weights are 0.
- R12: est_re_o/est_im_o keep their last value in cycles where est_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample strobe |
| in_re_i | input | 16 | Sample, in-phase, signed, scale 2^8 |
| in_im_i | input | 16 | Sample, quadrature, signed, scale 2^8 |
| h_we_i | input | 1 | Channel tap write enable |
| h_idx_i | input | clog2(2F+1) (3) | Channel tap index |
| h_re_i | input | 9 | Channel tap real part, signed, scale 2^8 |
| h_im_i | input | 9 | Channel tap imaginary part, signed, scale 2^8 |
| sigma_i | input | 9 | Signal power, signed, scale 2^8 |
| mu_i | input | 8 | Step size, unsigned, scale 2^18 |
| est_valid_o | output | 1 | Estimate strobe |
| est_re_o | output | 16 | Chip estimate, real, signed, scale 2^16 |
| est_im_o | output | 16 | Chip estimate, imaginary, signed, scale 2^16 |

## Verification
The latency and hold properties assume that reset is not reasserted inside the two-cycle window that follows a sample. The freeze property assumes mu_i is sampled at the edge where an update would occur. The stimulus therefore changes mu_i, sigma_i and the channel taps only at falling edges between samples, and holds reset low only at the start of the run. Inputs are always driven to known values; invalid cycles carry deliberately non-zero data to expose leaks into the window. Saturation phases use full-scale samples and the largest step size, so that weights and estimates reach both rails.

// File: rtl/gce_pkg.sv
package gce_pkg;

  function automatic logic signed [63:0] max_of(input int w);
    return (64'sd1 <<< (w - 1)) - 64'sd1;
  endfunction

  function automatic logic signed [63:0] min_of(input int w);
    return -(64'sd1 <<< (w - 1));
  endfunction

  function automatic logic signed [63:0] clamp(input logic signed [63:0] v, input int w);
    if (v > max_of(w)) return max_of(w);
    if (v < min_of(w)) return min_of(w);
    return v;
  endfunction

endpackage

// File: rtl/gce_window.sv
module gce_window #(
  parameter int NT = 5,
  parameter int XW = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   shift_i,
  input  logic [XW-1:0]          x_re_i,
  input  logic [XW-1:0]          x_im_i,
  output logic [NT-1:0][XW-1:0]  win_re_o,
  output logic [NT-1:0][XW-1:0]  win_im_o
);

  // index 0 holds the newest sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_re_o <= '0;
      win_im_o <= '0;
    end else if (shift_i) begin
      win_re_o[0] <= x_re_i;
      win_im_o[0] <= x_im_i;
      for (int k = 1; k < NT; k++) begin
        win_re_o[k] <= win_re_o[k-1];
        win_im_o[k] <= win_im_o[k-1];
      end
    end
  end

endmodule

// File: rtl/gce_coef_bank.sv
module gce_coef_bank #(
  parameter int NT = 5,
  parameter int HW = 9,
  parameter int IW = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IW-1:0]          idx_i,
  input  logic [HW-1:0]          re_i,
  input  logic [HW-1:0]          im_i,
  output logic [NT-1:0][HW-1:0]  h_re_o,
  output logic [NT-1:0][HW-1:0]  h_im_o
);

  logic [NT-1:0] hit;

  for (genvar k = 0; k < NT; k++) begin : g_dec
    assign hit[k] = we_i && (idx_i == IW'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_re_o <= '0;
      h_im_o <= '0;
    end else begin
      for (int k = 0; k < NT; k++) begin
        if (hit[k]) begin
          h_re_o[k] <= re_i;
          h_im_o[k] <= im_i;
        end
      end
    end
  end

endmodule

// File: rtl/gce_inner.sv
module gce_inner
  import gce_pkg::*;
#(
  parameter int NT    = 5,
  parameter int XW    = 16,
  parameter int WW    = 9,
  parameter int AW    = 32,
  parameter int OW    = 16,
  parameter int SHIFT = 6
) (
  input  logic [NT-1:0][XW-1:0]  win_re_i,
  input  logic [NT-1:0][XW-1:0]  win_im_i,
  input  logic [NT-1:0][WW-1:0]  w_re_i,
  input  logic [NT-1:0][WW-1:0]  w_im_i,
  output logic [OW-1:0]          est_re_o,
  output logic [OW-1:0]          est_im_o
);

  localparam int PW = XW + WW;

  logic signed [AW-1:0] t_re [NT];
  logic signed [AW-1:0] t_im [NT];

  // conj(w) * x per tap
  for (genvar k = 0; k < NT; k++) begin : g_tap
    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    assign p_rr = PW'($signed(w_re_i[k])) * PW'($signed(win_re_i[k]));
    assign p_ii = PW'($signed(w_im_i[k])) * PW'($signed(win_im_i[k]));
    assign p_ri = PW'($signed(w_re_i[k])) * PW'($signed(win_im_i[k]));
    assign p_ir = PW'($signed(w_im_i[k])) * PW'($signed(win_re_i[k]));
    assign t_re[k] = AW'(p_rr) + AW'(p_ii);
    assign t_im[k] = AW'(p_ri) - AW'(p_ir);
  end

  logic signed [AW-1:0] acc_re, acc_im;

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int k = 0; k < NT; k++) begin
      acc_re = acc_re + t_re[k];
      acc_im = acc_im + t_im[k];
    end
  end

  assign est_re_o = OW'(clamp(64'(acc_re >>> SHIFT), OW));
  assign est_im_o = OW'(clamp(64'(acc_im >>> SHIFT), OW));

endmodule

// File: rtl/gce_update.sv
module gce_update
  import gce_pkg::*;
#(
  parameter int NT    = 5,
  parameter int XW    = 16,
  parameter int WW    = 9,
  parameter int HW    = 9,
  parameter int MW    = 8,
  parameter int OW    = 16,
  parameter int AW    = 32,
  parameter int ALIGN = 8,
  parameter int SHIFT = 28
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   upd_i,
  input  logic [NT-1:0][XW-1:0]  win_re_i,
  input  logic [NT-1:0][XW-1:0]  win_im_i,
  input  logic [OW-1:0]          u_re_i,
  input  logic [OW-1:0]          u_im_i,
  input  logic [NT-1:0][HW-1:0]  h_re_i,
  input  logic [NT-1:0][HW-1:0]  h_im_i,
  input  logic [HW-1:0]          sigma_i,
  input  logic [MW-1:0]          mu_i,
  output logic [NT-1:0][WW-1:0]  w_re_o,
  output logic [NT-1:0][WW-1:0]  w_im_o
);

  localparam int            CT     = NT / 2;
  localparam logic [WW-1:0] W_INIT = {1'b0, {(WW-1){1'b1}}};

  logic signed [63:0] mu_s, sg, ur, ui;
  assign mu_s = 64'($signed({1'b0, mu_i}));
  assign sg   = 64'($signed(sigma_i));
  assign ur   = 64'($signed(u_re_i));
  assign ui   = 64'($signed(u_im_i));

  logic [WW-1:0] nw_re [NT];
  logic [WW-1:0] nw_im [NT];

  for (genvar k = 0; k < NT; k++) begin : g_tap
    logic signed [63:0] xr, xi, ru_re, ru_im, e_re, e_im, s_re, s_im;
    assign xr    = 64'($signed(win_re_i[k]));
    assign xi    = 64'($signed(win_im_i[k]));
    // r * conj(u_hat)
    assign ru_re = xr * ur + xi * ui;
    assign ru_im = xi * ur - xr * ui;
    // sigma*h aligned to the r*u scale, error held to AW bits
    assign e_re  = clamp(((sg * 64'($signed(h_re_i[k]))) <<< ALIGN) - ru_re, AW);
    assign e_im  = clamp(((sg * 64'($signed(h_im_i[k]))) <<< ALIGN) - ru_im, AW);
    assign s_re  = 64'($signed(w_re_o[k])) + ((e_re * mu_s) >>> SHIFT);
    assign s_im  = 64'($signed(w_im_o[k])) + ((e_im * mu_s) >>> SHIFT);
    assign nw_re[k] = WW'(clamp(s_re, WW));
    assign nw_im[k] = WW'(clamp(s_im, WW));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NT; k++) begin
        w_re_o[k] <= (k == CT) ? W_INIT : '0;
        w_im_o[k] <= '0;
      end
    end else if (upd_i) begin
      for (int k = 0; k < NT; k++) begin
        w_re_o[k] <= nw_re[k];
        w_im_o[k] <= nw_im[k];
      end
    end
  end

endmodule

// File: rtl/gce_chip_est.sv
module gce_chip_est #(
  parameter int F          = 2,
  parameter int XW         = 16,
  parameter int WW         = 9,
  parameter int HW         = 9,
  parameter int MW         = 8,
  parameter int OW         = 16,
  parameter int AW         = 32,
  parameter int PROD_SHIFT = 6,
  parameter int UPD_SHIFT  = 28,
  parameter int ALIGN      = 8,
  localparam int NT        = 2 * F + 1,
  localparam int IW        = $clog2(NT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [XW-1:0] in_re_i,
  input  logic [XW-1:0] in_im_i,
  input  logic          h_we_i,
  input  logic [IW-1:0] h_idx_i,
  input  logic [HW-1:0] h_re_i,
  input  logic [HW-1:0] h_im_i,
  input  logic [HW-1:0] sigma_i,
  input  logic [MW-1:0] mu_i,
  output logic          est_valid_o,
  output logic [OW-1:0] est_re_o,
  output logic [OW-1:0] est_im_o
);

  logic                  win_vld_q, est_vld_q;
  logic [NT-1:0][XW-1:0] win_re, win_im;
  logic [NT-1:0][HW-1:0] h_re, h_im;
  logic [NT-1:0][WW-1:0] w_re, w_im;
  logic [OW-1:0]         u_re, u_im, est_re_q, est_im_q;

  gce_window #(.NT(NT), .XW(XW)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (in_valid_i),
    .x_re_i   (in_re_i),
    .x_im_i   (in_im_i),
    .win_re_o (win_re),
    .win_im_o (win_im)
  );

  gce_coef_bank #(.NT(NT), .HW(HW), .IW(IW)) u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (h_we_i),
    .idx_i  (h_idx_i),
    .re_i   (h_re_i),
    .im_i   (h_im_i),
    .h_re_o (h_re),
    .h_im_o (h_im)
  );

  gce_inner #(
    .NT(NT), .XW(XW), .WW(WW), .AW(AW), .OW(OW), .SHIFT(PROD_SHIFT)
  ) u_inner (
    .win_re_i (win_re),
    .win_im_i (win_im),
    .w_re_i   (w_re),
    .w_im_i   (w_im),
    .est_re_o (u_re),
    .est_im_o (u_im)
  );

  gce_update #(
    .NT(NT), .XW(XW), .WW(WW), .HW(HW), .MW(MW), .OW(OW), .AW(AW),
    .ALIGN(ALIGN), .SHIFT(UPD_SHIFT)
  ) u_upd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (win_vld_q),
    .win_re_i (win_re),
    .win_im_i (win_im),
    .u_re_i   (u_re),
    .u_im_i   (u_im),
    .h_re_i   (h_re),
    .h_im_i   (h_im),
    .sigma_i  (sigma_i),
    .mu_i     (mu_i),
    .w_re_o   (w_re),
    .w_im_o   (w_im)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_vld_q <= 1'b0;
      est_vld_q <= 1'b0;
      est_re_q  <= '0;
      est_im_q  <= '0;
    end else begin
      win_vld_q <= in_valid_i;
      est_vld_q <= win_vld_q;
      if (win_vld_q) begin
        est_re_q <= u_re;
        est_im_q <= u_im;
      end
    end
  end

  assign est_valid_o = est_vld_q;
  assign est_re_o    = est_re_q;
  assign est_im_o    = est_im_q;

endmodule

// File: rtl/gce_chip_est_chk.sv
module gce_chip_est_chk #(
  parameter int NT = 5,
  parameter int XW = 16,
  parameter int WW = 9,
  parameter int MW = 8,
  parameter int OW = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  in_valid_i,
  input logic [MW-1:0]         mu_i,
  input logic                  est_valid_o,
  input logic [OW-1:0]         est_re_o,
  input logic [OW-1:0]         est_im_o,
  input logic [NT-1:0][XW-1:0] win_re,
  input logic [NT-1:0][XW-1:0] win_im,
  input logic [NT-1:0][WW-1:0] w_re,
  input logic [NT-1:0][WW-1:0] w_im
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r1: assert (!est_valid_o && est_re_o == '0 && est_im_o == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##2 est_valid_o);

  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##2 !est_valid_o);

  p_win_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(win_re) && $stable(win_im)));

  p_w_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##2 ($stable(w_re) && $stable(w_im)));

  p_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mu_i == '0) |=> ($stable(w_re) && $stable(w_im)));

  p_est_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !est_valid_o |-> ($stable(est_re_o) && $stable(est_im_o)));

endmodule

bind gce_chip_est gce_chip_est_chk #(
  .NT(NT), .XW(XW), .WW(WW), .MW(MW), .OW(OW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .mu_i        (mu_i),
  .est_valid_o (est_valid_o),
  .est_re_o    (est_re_o),
  .est_im_o    (est_im_o),
  .win_re      (win_re),
  .win_im      (win_im),
  .w_re        (w_re),
  .w_im        (w_im)
);

// File: tb/gce_chip_est_tb.sv
`timescale 1ns/1ps
module gce_chip_est_tb;

  localparam int F  = 2;
  localparam int NT = 2 * F + 1;
  localparam int IW = $clog2(NT);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          d_valid = 1'b0;
  logic [15:0]   d_xr = '0, d_xi = '0;
  logic          d_hwe = 1'b0;
  logic [IW-1:0] d_hidx = '0;
  logic [8:0]    d_hr = '0, d_hi = '0, d_sigma = '0;
  logic [7:0]    d_mu = '0;
  logic          est_valid;
  logic [15:0]   est_re, est_im;

  always #2.5 clk = ~clk;

  gce_chip_est #(.F(F)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (d_valid),
    .in_re_i     (d_xr),
    .in_im_i     (d_xi),
    .h_we_i      (d_hwe),
    .h_idx_i     (d_hidx),
    .h_re_i      (d_hr),
    .h_im_i      (d_hi),
    .sigma_i     (d_sigma),
    .mu_i        (d_mu),
    .est_valid_o (est_valid),
    .est_re_o    (est_re),
    .est_im_o    (est_im)
  );

  int    n_run = 0, n_fail = 0;
  string cur_req = "R4";

  // behavioural reference state
  longint m_xr[NT], m_xi[NT], m_wr[NT], m_wi[NT], m_hr[NT], m_hi[NT];
  bit     m_pend = 0, m_vld = 0;
  longint m_er = 0, m_ei = 0;

  function automatic longint clampv(longint v, int w);
    longint hi, lo;
    hi = (64'sd1 <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_edge();
    longint ar, ai, er, ei, sg, mu;
    sg = longint'($signed(d_sigma));
    mu = longint'(d_mu);
    if (m_pend) begin
      ar = 0; ai = 0;
      for (int k = 0; k < NT; k++) begin
        ar += m_wr[k] * m_xr[k] + m_wi[k] * m_xi[k];
        ai += m_wr[k] * m_xi[k] - m_wi[k] * m_xr[k];
      end
      m_er = clampv(ar >>> 6, 16);
      m_ei = clampv(ai >>> 6, 16);
      m_vld = 1;
      for (int k = 0; k < NT; k++) begin
        er = clampv(((sg * m_hr[k]) <<< 8) - (m_xr[k] * m_er + m_xi[k] * m_ei), 32);
        ei = clampv(((sg * m_hi[k]) <<< 8) - (m_xi[k] * m_er - m_xr[k] * m_ei), 32);
        m_wr[k] = clampv(m_wr[k] + ((er * mu) >>> 28), 9);
        m_wi[k] = clampv(m_wi[k] + ((ei * mu) >>> 28), 9);
      end
    end else begin
      m_vld = 0;
    end
    m_pend = d_valid;
    if (d_valid) begin
      for (int k = NT - 1; k > 0; k--) begin
        m_xr[k] = m_xr[k-1];
        m_xi[k] = m_xi[k-1];
      end
      m_xr[0] = longint'($signed(d_xr));
      m_xi[0] = longint'($signed(d_xi));
    end
    if (d_hwe && d_hidx < NT) begin
      m_hr[d_hidx] = longint'($signed(d_hr));
      m_hi[d_hidx] = longint'($signed(d_hi));
    end
  endfunction

  task automatic cyc(bit v, int xr, int xi);
    d_valid = v;
    d_xr = 16'(xr);
    d_xi = 16'(xi);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({cur_req, " valid"}, longint'(est_valid), longint'(m_vld));
    chk({cur_req, " re"}, longint'($signed(est_re)), m_er);
    chk({cur_req, " im"}, longint'($signed(est_im)), m_ei);
    d_hwe = 1'b0;
  endtask

  task automatic hload(int idx, int hr, int hi);
    d_hwe = 1'b1;
    d_hidx = IW'(idx);
    d_hr = 9'(hr);
    d_hi = 9'(hi);
    cyc(0, 0, 0);
  endtask

  task automatic flush();
    repeat (NT) cyc(1, 0, 0);
    cyc(0, 0, 0);
  endtask

  task automatic impulse(int xr, int xi);
    cyc(1, xr, xi);
    repeat (F) cyc(1, 0, 0);
    cyc(0, 0, 0);
  endtask

  initial begin
    for (int k = 0; k < NT; k++) begin
      m_xr[k] = 0; m_xi[k] = 0; m_hr[k] = 0; m_hi[k] = 0;
      m_wr[k] = (k == F) ? 255 : 0;
      m_wi[k] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", longint'(est_valid), 0);
    chk("R1 re in reset", longint'($signed(est_re)), 0);
    chk("R1 im in reset", longint'($signed(est_im)), 0);
    rst_n = 1'b1;

    // R11/R3: centre weight 255 applied to the chip F samples back
    cur_req = "R11";
    impulse(1000, 0);
    chk("R3 centre tap re", longint'($signed(est_re)), 3984);
    chk("R11 centre tap im", longint'($signed(est_im)), 0);

    // R2: lone sample, strobe exactly two edges later
    cur_req = "R2";
    flush();
    d_valid = 1'b1; d_xr = 16'd500; d_xi = 16'd0;
    @(posedge clk); model_edge(); @(negedge clk);
    chk("R2 not yet valid", longint'(est_valid), 0);
    d_valid = 1'b0;
    @(posedge clk); model_edge(); @(negedge clk);
    chk("R2 valid after two edges", longint'(est_valid), 1);
    @(posedge clk); model_edge(); @(negedge clk);
    chk("R2 single pulse", longint'(est_valid), 0);

    // R4: floor on negative result
    cur_req = "R4";
    flush();
    impulse(-1000, 0);
    chk("R4 floor shift", longint'($signed(est_re)), -3985);

    // R7: both rails
    cur_req = "R7";
    flush();
    impulse(32767, -32768);
    chk("R7 positive rail", longint'($signed(est_re)), 32767);
    chk("R7 negative rail", longint'($signed(est_im)), -32768);

    // R10: invalid cycles carry junk that must not enter the window
    cur_req = "R10";
    flush();
    cyc(1, 1000, 0);
    cyc(0, 5000, 5000);
    cyc(1, 0, 0);
    cyc(0, 777, -1);
    cyc(1, 0, 0);
    cyc(0, -3000, 42);
    chk("R10 gaps ignored", longint'($signed(est_re)), 3984);
    // R12: hold while idle
    cyc(0, 1234, 1234);
    chk("R12 re held", longint'($signed(est_re)), 3984);
    chk("R12 valid low", longint'(est_valid), 0);

    // R9: no drift after many samples with zero step
    cur_req = "R9";
    flush();
    impulse(1000, 0);
    chk("R9 weights frozen", longint'($signed(est_re)), 3984);

    // R8: channel load, out-of-range index ignored
    cur_req = "R8";
    hload(F, 128, 0);
    hload(1, -40, 20);
    hload(6, 255, 255);
    hload(3, 10, -30);

    // R5: adaptation with moderate signals
    cur_req = "R5";
    d_sigma = 9'd64;
    d_mu = 8'd20;
    for (int i = 0; i < 80; i++) begin
      cyc((i % 7) != 3, int'($urandom_range(0, 6000)) - 3000,
          int'($urandom_range(0, 6000)) - 3000);
    end

    // R6: large step and full-scale signals drive weights to the rails
    cur_req = "R6";
    d_sigma = 9'd255;
    d_mu = 8'd255;
    for (int i = 0; i < 60; i++) begin
      cyc(1, int'($urandom_range(0, 60000)) - 30000,
          int'($urandom_range(0, 60000)) - 30000);
    end
    d_mu = 8'd0;
    cur_req = "R6 probe";
    for (int i = 0; i < 20; i++) begin
      cyc(1, int'($urandom_range(0, 2000)) - 1000, 0);
    end
    cyc(0, 0, 0);
    cyc(0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule